// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes written through a small register port into asynchronous serial frames on a single output line. Each frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Every bit lasts one period of an external bit-rate strobe. One control register sets the options. The transmitter starts a frame only while its enable bit is set. When the clear-to-send gate is on, the active-low clear-to-send input must also be low.

Setting the break request bit pulls the line low at once and abandons any frame in progress. In standard mode the line stays low for as long as software holds the request, and software then times any stop bits. In bus mode, chosen by the `lin_mode` input, hardware counts 13 to 16 bit times as set by `brk_len`. It then clears the request bit on its own and holds the line high for one bit time before it returns to idle.

The state machine has these states: IDLE, START, DATA, PARITY, STOP1, STOP2, BRK_SW (break held by software), BRK_HW (break timed by hardware) and BRK_END (one high bit after a timed break). The transitions are:
- IDLE→START on a strobe when a byte is pending and sending is allowed.
- START→DATA on a strobe.
- DATA→DATA on a strobe, once for each of the first seven bits.
- DATA→PARITY or DATA→STOP1 after the eighth bit, depending on whether parity is on.
- PARITY→STOP1 on a strobe.
- STOP1→STOP2 when two stop bits are chosen.
- From the last stop state: →START if another byte may go out, →IDLE otherwise.
- Any non-break state →BRK_SW or →BRK_HW while the request bit is set.
- BRK_SW→IDLE when software clears the request.
- BRK_HW→BRK_END when the count expires.
- BRK_END→IDLE on a strobe.

Top module: `lin_tx_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is high, and `busy` and `done` are low.
- R2: A frame is a low start bit, then the eight data bits with the least significant bit first, then stop bits that are high. Each bit lasts one `bit_tick` period. When no frame or break is active the line is high.
- R3: When control bit 4 (parity on) is 1, one parity bit follows the data bits. With control bit 3 at 0 the parity is even: the parity bit is 1 when the data holds an odd number of ones. When control bit 4 is 0, no parity bit is sent.
- R4: When control bit 3 is 1, the parity is odd: the parity bit is 1 when the data holds an even number of ones.
- R5: Control bit 1 selects one stop bit when 0 and two stop bits when 1. `busy` is high for exactly 10, 11 or 12 bit periods for one stop bit, two stop bits, or parity plus two stop bits.
- R6: With control bit 7 (transmit enable) at 0, no frame starts and a byte that was written stays pending. It goes out once the bit is set.
- R7: With control bit 5 (clear-to-send gate) at 1, a frame starts only while `cts_n` is low. With the gate at 0, `cts_n` has no effect.
- R8: Clearing transmit enable during a frame lets that frame finish intact, and a byte queued behind it is not started.
- R9: With `lin_mode` low, setting control bit 2 (break request) drives `txd` low within two clock cycles, abandoning any frame in progress. The line stays low and the bit stays set until software clears it, and the line is high again within two cycles after that.
- R10: With `lin_mode` high, setting the break request holds `txd` low for exactly 13+`brk_len` bit periods. Hardware then clears control bit 2 and the line is high for at least one bit period.
- R11: `done` pulses high for one clock when the last stop bit of a frame ends. An abandoned frame gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes the control register, 1 writes the byte to send |
| wr_data | input | 8 | Write data |
| bit_tick | input | 1 | One-clock strobe marking each bit period |
| cts_n | input | 1 | Active-low clear-to-send |
| lin_mode | input | 1 | 1 selects the hardware-timed break |
| brk_len | input | 2 | Timed break length minus 13, in bit periods |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at the end of a frame |
| ctrl_out | output | 8 | Current control register value |

## Verification
The bench goes after parity polarity with data that holds both odd and even numbers of ones. A flipped parity sense or a parity bit sent while parity is off would shift the stop bit or the parity value. It counts busy periods for each stop and parity setting, so a design that miscounts stop bits or inserts an extra idle bit would be one period off. It sets a break in the middle of a frame and checks that the line drops at once and that no completion pulse follows. It counts the low periods of a timed break at the shortest and longest lengths, which exposes an off-by-one counter or a request bit that never clears. It also drops the enable and the clear-to-send input while bytes are pending, so a design that ignores either one, or one that cuts the current frame short, would emit or lose a frame.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

    localparam int CTRL_W = 8;

    // control register bit positions
    localparam int B_TX_ON    = 7;
    localparam int B_RX_ON    = 6;
    localparam int B_CTS_GATE = 5;
    localparam int B_PAR_ON   = 4;
    localparam int B_PAR_ODD  = 3;
    localparam int B_BRK_REQ  = 2;
    localparam int B_STOP_TWO = 1;
    localparam int B_LOOP     = 0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP1,
        S_STOP2,
        S_BRK_SW,
        S_BRK_HW,
        S_BRK_END
    } tx_state_t;

endpackage

// File: rtl/lin_tx_regs.sv
module lin_tx_regs
    import lin_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_clr,
    input  logic              take,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              pend_q,
    output logic [DATA_W-1:0] hold_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pend_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (brk_clr)
                ctrl_q[B_BRK_REQ] <= 1'b0;
            if (wr_en && !wr_sel)
                ctrl_q <= wr_data[CTRL_W-1:0];
            if (take)
                pend_q <= 1'b0;
            if (wr_en && wr_sel) begin
                hold_q <= wr_data;
                pend_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lin_tx_brk_timer.sv
module lin_tx_brk_timer #(
    parameter int BASE  = 13,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);

    localparam int CNT_W = $clog2(BASE + (1 << LEN_W));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit  = CNT_W'(BASE) + CNT_W'(len) - CNT_W'(1);
    assign expire = run && tick && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (arm)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/lin_tx_fsm.sv
module lin_tx_fsm
    import lin_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_ok,
    input  logic              pend,
    input  logic [DATA_W-1:0] hold,
    input  logic              brk_req,
    input  logic              lin_mode,
    input  logic              par_on,
    input  logic              par_odd,
    input  logic              stop_two,
    input  logic              brk_expire,
    output logic              take,
    output logic              brk_arm,
    output logic              brk_run,
    output logic              txd,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

    tx_state_t         state_q, nxt;
    logic [IDX_W-1:0]  idx_q, nidx;
    logic [DATA_W-1:0] byte_q;
    logic              done_q;
    logic              fin;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            byte_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            idx_q   <= nidx;
            done_q  <= fin;
            if (take)
                byte_q <= hold;
        end
    end

    // next state
    always_comb begin
        nxt  = state_q;
        nidx = idx_q;
        take = 1'b0;
        fin  = 1'b0;
        if (brk_req && state_q != S_BRK_SW && state_q != S_BRK_HW) begin
            nxt = lin_mode ? S_BRK_HW : S_BRK_SW;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (tick && pend && tx_ok) begin
                        nxt  = S_START;
                        take = 1'b1;
                    end
                end
                S_START: begin
                    if (tick) begin
                        nxt  = S_DATA;
                        nidx = '0;
                    end
                end
                S_DATA: begin
                    if (tick) begin
                        if (idx_q == LAST)
                            nxt = par_on ? S_PARITY : S_STOP1;
                        else
                            nidx = idx_q + IDX_W'(1);
                    end
                end
                S_PARITY: begin
                    if (tick)
                        nxt = S_STOP1;
                end
                S_STOP1, S_STOP2: begin
                    if (tick) begin
                        if (state_q == S_STOP1 && stop_two) begin
                            nxt = S_STOP2;
                        end else begin
                            fin = 1'b1;
                            if (pend && tx_ok) begin
                                nxt  = S_START;
                                take = 1'b1;
                            end else begin
                                nxt = S_IDLE;
                            end
                        end
                    end
                end
                S_BRK_SW: begin
                    if (!brk_req)
                        nxt = S_IDLE;
                end
                S_BRK_HW: begin
                    if (brk_expire)
                        nxt = S_BRK_END;
                end
                S_BRK_END: begin
                    if (tick)
                        nxt = S_IDLE;
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    assign brk_arm = (nxt == S_BRK_HW) && (state_q != S_BRK_HW);

    // outputs
    always_comb begin
        txd     = 1'b1;
        busy    = 1'b0;
        brk_run = 1'b0;
        unique case (state_q)
            S_IDLE:    txd = 1'b1;
            S_START:   begin txd = 1'b0;             busy = 1'b1; end
            S_DATA:    begin txd = byte_q[idx_q];    busy = 1'b1; end
            S_PARITY:  begin txd = ^byte_q ^ par_odd; busy = 1'b1; end
            S_STOP1,
            S_STOP2:   begin txd = 1'b1;             busy = 1'b1; end
            S_BRK_SW:  txd = 1'b0;
            S_BRK_HW:  begin txd = 1'b0; brk_run = 1'b1; end
            S_BRK_END: txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    assign done = done_q;

endmodule

// File: rtl/lin_tx_ctrl.sv
module lin_tx_ctrl
    import lin_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BRK_BASE  = 13,
    parameter int BRK_LEN_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 bit_tick,
    input  logic                 cts_n,
    input  logic                 lin_mode,
    input  logic [BRK_LEN_W-1:0] brk_len,
    output logic                 txd,
    output logic                 busy,
    output logic                 done,
    output logic [CTRL_W-1:0]    ctrl_out
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic              pend_q;
    logic              take;
    logic              brk_arm;
    logic              brk_run;
    logic              brk_expire;
    logic              tx_ok;

    assign tx_ok    = ctrl_q[B_TX_ON] && (!ctrl_q[B_CTS_GATE] || !cts_n);
    assign ctrl_out = ctrl_q;

    lin_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .brk_clr (brk_expire),
        .take    (take),
        .ctrl_q  (ctrl_q),
        .pend_q  (pend_q),
        .hold_q  (hold_q)
    );

    lin_tx_brk_timer #(.BASE(BRK_BASE), .LEN_W(BRK_LEN_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (brk_arm),
        .run    (brk_run),
        .tick   (bit_tick),
        .len    (brk_len),
        .expire (brk_expire)
    );

    lin_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .tx_ok      (tx_ok),
        .pend       (pend_q),
        .hold       (hold_q),
        .brk_req    (ctrl_q[B_BRK_REQ]),
        .lin_mode   (lin_mode),
        .par_on     (ctrl_q[B_PAR_ON]),
        .par_odd    (ctrl_q[B_PAR_ODD]),
        .stop_two   (ctrl_q[B_STOP_TWO]),
        .brk_expire (brk_expire),
        .take       (take),
        .brk_arm    (brk_arm),
        .brk_run    (brk_run),
        .txd        (txd),
        .busy       (busy),
        .done       (done)
    );

endmodule

// File: rtl/lin_tx_ctrl_chk.sv
module lin_tx_ctrl_chk
    import lin_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              cts_n,
    input logic              lin_mode,
    input logic              txd,
    input logic              busy,
    input logic              done,
    input logic [CTRL_W-1:0] ctrl_out
);

    // R2: line high whenever no frame and no break is pending
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_out[B_BRK_REQ] && !$past(ctrl_out[B_BRK_REQ])) |-> txd);

    // R6 / R7: a frame starts only when enabled and clear-to-send allows it
    a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ctrl_out[B_TX_ON]) &&
                         (!$past(ctrl_out[B_CTS_GATE]) || !$past(cts_n))));

    // R9: a held break request keeps the line low
    a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out[B_BRK_REQ] && $past(ctrl_out[B_BRK_REQ])) |-> !txd);

    // R10: self-clear of the request releases the line high
    a_r10_lin_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && $fell(ctrl_out[B_BRK_REQ]) && !$past(wr_en)) |-> txd);

    // R11: completion pulse lasts one clock
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind lin_tx_ctrl lin_tx_ctrl_chk u_chk (.*);

// File: tb/lin_tx_ctrl_test.sv
`timescale 1ns/1ps
module lin_tx_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick = 1'b0;
    logic       cts_n = 1'b0;
    logic       lin_mode = 1'b0;
    logic [1:0] brk_len = 2'd0;
    logic       txd, busy, done;
    logic [7:0] ctrl_out;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    lin_tx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bit_tick(bit_tick), .cts_n(cts_n),
        .lin_mode(lin_mode), .brk_len(brk_len), .txd(txd), .busy(busy),
        .done(done), .ctrl_out(ctrl_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bit-rate strobe, line and busy sampling once per bit period
    int tick_div = 0;
    int tick_n = 0;
    int busy_ticks = 0;
    int done_n = 0;
    bit line_q[$];

    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 4;
        bit_tick <= (tick_div == 0);
        if (tick_div == 0) begin
            line_q.push_back(txd);
            if (busy) busy_ticks++;
            tick_n++;
        end
        if (done) done_n++;
    end

    // behavioural reference model
    int         m_ph = 0;   // 0 idle 1 start 2 data 3 parity 4 stop1 5 stop2 6 swbrk 7 hwbrk 8 brk_end
    int         m_idx = 0;
    int         m_cnt = 0;
    logic [7:0] m_ctrl = 8'h00, m_hold = 8'h00, m_byte = 8'h00;
    bit         m_pend = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_cnt = 0; m_ctrl = 0; m_hold = 0;
            m_byte = 0; m_pend = 0; m_done = 0;
        end else begin
            bit ok, take, fin, clr;
            int nph;
            ok = m_ctrl[7] && (!m_ctrl[5] || !cts_n);
            take = 0; fin = 0; clr = 0; nph = m_ph;
            if (m_ctrl[2] && m_ph != 6 && m_ph != 7) begin
                nph = lin_mode ? 7 : 6;
                m_cnt = 0;
            end else begin
                case (m_ph)
                    0: if (bit_tick && m_pend && ok) begin nph = 1; take = 1; end
                    1: if (bit_tick) begin nph = 2; m_idx = 0; end
                    2: if (bit_tick) begin
                           if (m_idx == 7) nph = m_ctrl[4] ? 3 : 4;
                           else m_idx++;
                       end
                    3: if (bit_tick) nph = 4;
                    4, 5: if (bit_tick) begin
                           if (m_ph == 4 && m_ctrl[1]) nph = 5;
                           else begin
                               fin = 1;
                               if (m_pend && ok) begin nph = 1; take = 1; end
                               else nph = 0;
                           end
                       end
                    6: if (!m_ctrl[2]) nph = 0;
                    7: if (bit_tick) begin
                           if (m_cnt == 12 + int'(brk_len)) begin nph = 8; clr = 1; end
                           else m_cnt++;
                       end
                    8: if (bit_tick) nph = 0;
                    default: nph = 0;
                endcase
            end
            if (take) begin m_byte = m_hold; m_pend = 0; end
            if (clr) m_ctrl[2] = 1'b0;
            if (wr_en && !wr_sel) m_ctrl = wr_data;
            if (wr_en && wr_sel) begin m_hold = wr_data; m_pend = 1; end
            m_done = fin;
            m_ph = nph;
        end
    end

    function automatic bit model_txd();
        case (m_ph)
            1: return 1'b0;
            2: return m_byte[m_idx];
            3: return ^m_byte ^ m_ctrl[3];
            6, 7: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check(txd == model_txd(), "R2 model txd", txd, model_txd());
            check(busy == (m_ph >= 1 && m_ph <= 5), "R11 model busy", busy, (m_ph >= 1 && m_ph <= 5));
            check(done == m_done, "R11 model done", done, m_done);
            check(ctrl_out == m_ctrl, "R10 model ctrl", ctrl_out, m_ctrl);
        end
    end

    task automatic wr(input bit sel, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int t;
        t = tick_n + n;
        while (tick_n < t) @(negedge clk);
    endtask

    task automatic wait_busy();
        @(negedge clk);
        while (!busy) @(negedge clk);
    endtask

    task automatic clear_log();
        line_q.delete();
        busy_ticks = 0;
        done_n = 0;
    endtask

    function automatic int first_zero();
        foreach (line_q[i]) if (line_q[i] == 1'b0) return i;
        return -1;
    endfunction

    function automatic int zero_count();
        int z = 0;
        foreach (line_q[i]) if (line_q[i] == 1'b0) z++;
        return z;
    endfunction

    function automatic logic [7:0] decode(input int fz);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = line_q[fz + 1 + k];
        return b;
    endfunction

    task automatic send_frame(input logic [7:0] ctl, input logic [7:0] v);
        clear_log();
        wr(1'b0, ctl);
        wr(1'b1, v);
        wait_ticks(16);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int fz;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(ctrl_out == 8'h00, "R1 ctrl", ctrl_out, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 basic frame, R5 one stop, R11 done pulse
        send_frame(8'h80, 8'hA5);
        fz = first_zero();
        check(fz >= 0, "R2 start bit", fz, 0);
        check(decode(fz) == 8'hA5, "R2 data lsb first", decode(fz), 8'hA5);
        check(line_q[fz + 9] == 1'b1, "R2 stop bit", line_q[fz + 9], 1);
        check(busy_ticks == 10, "R5 one stop length", busy_ticks, 10);
        check(done_n == 1, "R11 one done pulse", done_n, 1);

        // R3 even parity
        send_frame(8'h90, 8'h07);
        fz = first_zero();
        check(line_q[fz + 9] == 1'b1, "R3 even parity odd ones", line_q[fz + 9], 1);
        check(line_q[fz + 10] == 1'b1, "R3 stop after parity", line_q[fz + 10], 1);
        send_frame(8'h90, 8'h03);
        fz = first_zero();
        check(line_q[fz + 9] == 1'b0, "R3 even parity even ones", line_q[fz + 9], 0);
        check(busy_ticks == 11, "R3 parity adds one bit", busy_ticks, 11);

        // R4 odd parity
        send_frame(8'h98, 8'h07);
        fz = first_zero();
        check(line_q[fz + 9] == 1'b0, "R4 odd parity odd ones", line_q[fz + 9], 0);
        send_frame(8'h98, 8'h00);
        fz = first_zero();
        check(line_q[fz + 9] == 1'b1, "R4 odd parity zero ones", line_q[fz + 9], 1);

        // R5 stop bit count
        send_frame(8'h82, 8'h3C);
        check(busy_ticks == 11, "R5 two stop length", busy_ticks, 11);
        send_frame(8'h9A, 8'h3C);
        check(busy_ticks == 12, "R5 parity two stop length", busy_ticks, 12);

        // R6 transmit enable gating
        clear_log();
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h55);
        wait_ticks(30);
        check(zero_count() == 0, "R6 no frame when disabled", zero_count(), 0);
        check(busy_ticks == 0, "R6 busy stays low", busy_ticks, 0);
        clear_log();
        wr(1'b0, 8'h80);
        wait_ticks(16);
        fz = first_zero();
        check(fz >= 0 && decode(fz) == 8'h55, "R6 pending byte sent", decode(fz), 8'h55);

        // R7 clear-to-send qualification
        clear_log();
        cts_n = 1'b1;
        wr(1'b0, 8'hA0);
        wr(1'b1, 8'h66);
        wait_ticks(30);
        check(zero_count() == 0, "R7 blocked by cts_n high", zero_count(), 0);
        clear_log();
        cts_n = 1'b0;
        wait_ticks(16);
        fz = first_zero();
        check(fz >= 0 && decode(fz) == 8'h66, "R7 sent when cts_n low", decode(fz), 8'h66);
        clear_log();
        cts_n = 1'b1;
        wr(1'b0, 8'h80);
        wr(1'b1, 8'h99);
        wait_ticks(16);
        fz = first_zero();
        check(fz >= 0 && decode(fz) == 8'h99, "R7 cts_n ignored when gate off", decode(fz), 8'h99);
        cts_n = 1'b0;

        // R8 disable during frame
        clear_log();
        wr(1'b1, 8'h81);
        wait_busy();
        wr(1'b1, 8'h42);
        wait_ticks(3);
        wr(1'b0, 8'h00);
        wait_ticks(25);
        fz = first_zero();
        check(fz >= 0 && decode(fz) == 8'h81, "R8 current frame intact", decode(fz), 8'h81);
        check(zero_count() == 7, "R8 queued byte not started", zero_count(), 7);
        check(done_n == 1, "R8 frame completed", done_n, 1);

        // R9 software-timed break, abandons the frame of byte 0x42
        wr(1'b0, 8'h80);
        wait_busy();
        wait_ticks(3);
        done_n = 0;
        wr(1'b0, 8'h84);
        @(negedge clk);
        check(txd == 1'b0, "R9 break immediate", txd, 0);
        check(busy == 1'b0, "R9 frame abandoned", busy, 0);
        wait_ticks(40);
        check(txd == 1'b0, "R9 break held", txd, 0);
        check(ctrl_out == 8'h84, "R9 request not self-cleared", ctrl_out, 8'h84);
        wr(1'b0, 8'h00);
        @(negedge clk);
        check(txd == 1'b1, "R9 line released", txd, 1);
        check(done_n == 0, "R11 no done for abandoned frame", done_n, 0);

        // R10 hardware-timed break, shortest and longest
        lin_mode = 1'b1;
        brk_len = 2'd0;
        clear_log();
        wr(1'b0, 8'h04);
        wait_ticks(25);
        check(zero_count() == 13, "R10 break length 13", zero_count(), 13);
        check(ctrl_out == 8'h00, "R10 request self-cleared", ctrl_out, 0);
        check(txd == 1'b1, "R10 line high after break", txd, 1);
        brk_len = 2'd3;
        clear_log();
        wr(1'b0, 8'h04);
        wait_ticks(25);
        fz = first_zero();
        check(zero_count() == 16, "R10 break length 16", zero_count(), 16);
        check(line_q[fz + 16] == 1'b1, "R10 high bit after break", line_q[fz + 16], 1);
        check(ctrl_out == 8'h00, "R10 request cleared again", ctrl_out, 0);

        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule